// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor

This block is a small sequential processor built around one working register R. It runs a fixed fetch, decode and execute loop over 16-bit instruction words. Each word names an operation in its top four bits and one memory operand address in its low twelve bits. Several operations act directly on the memory cell named by the operand and leave R alone. Program flow is steered by three mutually exclusive comparison flags. Only the compare operation sets them.

All memory traffic goes through a synchronous single-port word memory with one cycle of read latency. The block drives that memory from an address register and a data register. Two valid/ready ports move words into and out of the processor for the input and output operations. The halt operation parks the processor until the next reset.

Top module: `acc1_cpu`

## Requirements
- R1: While reset is held, `halted`, `mem_we`, `in_ready` and `out_valid` are low. After release the first instruction is read from address 0. Reset clears the program counter, R and the flags.
- R2: The opcode is bits [15:12] and the operand address X is bits [11:0]. Code 0 loads R from M[X], 1 stores R to M[X], 3 adds M[X] to R and 5 subtracts M[X] from R. Arithmetic is 16-bit two's complement and wraps.
- R3: Code 4 writes M[X]+1 back to M[X], code 6 writes M[X]−1 and code 2 writes zero. None of them changes R.
- R4: Code 7 makes exactly one flag true: greater when M[X] > R, equal when M[X] = R, less when M[X] < R. The ordering is signed.
- R5: Code 8 always jumps to X. Codes 9, 10 and 11 jump when greater, equal or less is set. Code 12 jumps when equal is clear. The flags keep their value across every operation other than compare.
- R6: With no jump taken, instructions run from consecutive addresses. The program counter steps by one after each fetch.
- R7: Code 13 raises `in_ready` and waits. When `in_valid` is also high at a clock edge, the port word is taken and written to M[X].
- R8: Code 14 raises `out_valid` with M[X] on `out_data`. The value is held stable until `out_ready` is seen at a clock edge.
- R9: Code 15 sets `halted`, which stays high until reset. After that no memory write and no port handshake occurs.
- R10: Counted from one fetch to the next, store, clear and every jump take 4 cycles. Load, add, subtract and compare take 5. Increment and decrement take 6. Input takes 5 and output takes 6 when the port side answers at once. Halt raises `halted` 3 cycles after its fetch begins.
- R11: A memory write lasts exactly one cycle. It never coincides with a port handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Word address to memory |
| mem_we | output | 1 | Write strobe for the addressed word |
| mem_wdata | output | 16 | Word written when `mem_we` is high |
| mem_rdata | input | 16 | Word read, valid one cycle after its address |
| in_valid | input | 1 | Input word available |
| in_ready | output | 1 | Processor waiting for an input word |
| in_data | input | 16 | Input word |
| out_valid | output | 1 | Output word presented |
| out_ready | input | 1 | Consumer accepts output word |
| out_data | output | 16 | Output word |
| halted | output | 1 | Processor has stopped |

## Verification
The properties assume that the memory returns the addressed word on the cycle after the address. They also assume that the port partners never depend on anything other than the current valid and ready levels. The bench memory model and its port drivers satisfy both. Port stalls follow fixed periodic patterns, so the wait in the input and output states varies while every handshake stays legal. Programs keep all addresses inside the small modelled memory. Each program ends in halt, so the sticky-halt and quiet-after-halt properties are exercised every run.

// File: rtl/acc1_pkg.sv
package acc1_pkg;
    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 4'd0,  OP_STORE = 4'd1,  OP_CLEAR = 4'd2,  OP_ADD  = 4'd3,
        OP_INC   = 4'd4,  OP_SUB   = 4'd5,  OP_DEC   = 4'd6,  OP_CMP  = 4'd7,
        OP_JMP   = 4'd8,  OP_JGT   = 4'd9,  OP_JEQ   = 4'd10, OP_JLT  = 4'd11,
        OP_JNE   = 4'd12, OP_IN    = 4'd13, OP_OUT   = 4'd14, OP_HALT = 4'd15
    } op_e;

    // FETCH_ADDR must encode as zero: the register block resets to all zeros
    typedef enum logic [2:0] {
        S_FETCH_ADDR   = 3'd0,
        S_FETCH_WAIT   = 3'd1,
        S_DECODE       = 3'd2,
        S_OPERAND_READ = 3'd3,
        S_EXECUTE      = 3'd4,
        S_WRITEBACK    = 3'd5,
        S_IO_WAIT      = 3'd6,
        S_HALT         = 3'd7
    } state_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cc_t;
endpackage

// File: rtl/acc1_alu.sv
module acc1_alu
    import acc1_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] acc_res,
    output logic [DATA_W-1:0] mem_res,
    output cc_t               cmp
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        unique case (op)
            OP_ADD:  acc_res = acc + opnd;
            OP_SUB:  acc_res = acc - opnd;
            default: acc_res = opnd;
        endcase
        unique case (op)
            OP_INC:  mem_res = opnd + ONE;
            OP_DEC:  mem_res = opnd - ONE;
            default: mem_res = opnd;
        endcase
        cmp.gt = $signed(opnd) >  $signed(acc);
        cmp.eq = opnd == acc;
        cmp.lt = $signed(opnd) <  $signed(acc);
    end
endmodule

// File: rtl/acc1_branch.sv
module acc1_branch
    import acc1_pkg::*;
(
    input  op_e  op,
    input  cc_t  cc,
    output logic take
);
    always_comb begin
        unique case (op)
            OP_JMP:  take = 1'b1;
            OP_JGT:  take = cc.gt;
            OP_JEQ:  take = cc.eq;
            OP_JLT:  take = cc.lt;
            OP_JNE:  take = !cc.eq;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc1_cpu.sv
module acc1_cpu
    import acc1_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              halted
);
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mdr;
        cc_t               cc;
    } regs_t;

    regs_t q, d;

    op_e               dec_op, ir_op;
    logic [DATA_W-1:0] alu_acc, alu_mem;
    cc_t               alu_cc;
    logic              br_take;
    logic [2:0]        cc_flags;

    assign dec_op   = op_e'(mem_rdata[DATA_W-1 -: OPC_W]);
    assign ir_op    = op_e'(q.ir[DATA_W-1 -: OPC_W]);
    assign cc_flags = q.cc;

    acc1_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (ir_op),
        .acc     (q.acc),
        .opnd    (mem_rdata),
        .acc_res (alu_acc),
        .mem_res (alu_mem),
        .cmp     (alu_cc)
    );

    acc1_branch u_branch (
        .op   (ir_op),
        .cc   (q.cc),
        .take (br_take)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            S_FETCH_ADDR: begin
                d.mar = q.pc;
                d.st  = S_FETCH_WAIT;
            end
            S_FETCH_WAIT: d.st = S_DECODE;
            S_DECODE: begin
                d.ir  = mem_rdata;
                d.pc  = q.pc + PC_STEP;
                d.mar = mem_rdata[ADDR_W-1:0];
                unique case (dec_op)
                    OP_STORE: begin
                        d.mdr = q.acc;
                        d.st  = S_WRITEBACK;
                    end
                    OP_CLEAR: begin
                        d.mdr = '0;
                        d.st  = S_WRITEBACK;
                    end
                    OP_JMP, OP_JGT, OP_JEQ, OP_JLT, OP_JNE: d.st = S_EXECUTE;
                    OP_IN:   d.st = S_IO_WAIT;
                    OP_HALT: d.st = S_HALT;
                    default: d.st = S_OPERAND_READ;
                endcase
            end
            S_OPERAND_READ: d.st = S_EXECUTE;
            S_EXECUTE: begin
                d.mdr = alu_mem;
                d.st  = S_FETCH_ADDR;
                unique case (ir_op)
                    OP_LOAD, OP_ADD, OP_SUB: d.acc = alu_acc;
                    OP_CMP:          d.cc = alu_cc;
                    OP_INC, OP_DEC:  d.st = S_WRITEBACK;
                    OP_OUT:          d.st = S_IO_WAIT;
                    default: begin
                        if (br_take) d.pc = q.ir[ADDR_W-1:0];
                    end
                endcase
            end
            S_WRITEBACK: d.st = S_FETCH_ADDR;
            S_IO_WAIT: begin
                if (ir_op == OP_IN) begin
                    if (in_valid) begin
                        d.mdr = in_data;
                        d.st  = S_WRITEBACK;
                    end
                end else if (out_ready) begin
                    d.st = S_FETCH_ADDR;
                end
            end
            default: d.st = S_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_addr  = q.mar;
    assign mem_we    = q.st == S_WRITEBACK;
    assign mem_wdata = q.mdr;
    assign in_ready  = (q.st == S_IO_WAIT) && (ir_op == OP_IN);
    assign out_valid = (q.st == S_IO_WAIT) && (ir_op != OP_IN);
    assign out_data  = q.mdr;
    assign halted    = q.st == S_HALT;
endmodule

// File: rtl/acc1_cpu_chk.sv
module acc1_cpu_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              halted,
    input logic [2:0]        cc
);
    a_r8_out_held: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    a_r7_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && !in_valid |=> in_ready);

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we && !in_ready && !out_valid);

    a_r11_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r11_write_not_io: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !in_ready && !out_valid);

    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cc));

    a_r4_flags_set_once_compared: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc) == 1 |=> $countones(cc) == 1);
endmodule

bind acc1_cpu acc1_cpu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .halted    (halted),
    .cc        (cc_flags)
);

// File: tb/acc1_cpu_bench.sv
module acc1_cpu_bench;
    localparam logic [3:0] LD = 4'd0, ST = 4'd1, CL = 4'd2, AD = 4'd3, IC = 4'd4,
                           SB = 4'd5, DC = 4'd6, CP = 4'd7, JP = 4'd8, JG = 4'd9,
                           JE = 4'd10, JL = 4'd11, JN = 4'd12, IN = 4'd13,
                           OT = 4'd14, HL = 4'd15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic        halted;

    always #5 clk = ~clk;

    acc1_cpu u_acc1_cpu (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .halted(halted)
    );

    logic [15:0] bmem [0:255];
    logic [15:0] sm   [0:255];
    logic [15:0] in_list [$];
    int          in_idx;
    logic [11:0] exp_wa [$];
    logic [15:0] exp_wd [$];
    logic [15:0] exp_out [$];
    int          exp_cyc;
    int          checks = 0;
    int          fails = 0;
    bit          active = 0;
    bit          stall_mode = 0;
    int          cyc = 0;
    int          total_cyc = 0;

    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= bmem[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] ins(input logic [3:0] op, input int x);
        return {op, 12'(x)};
    endfunction

    // behavioural reference: executes the program image and records events
    task automatic run_iss();
        logic [15:0] r = '0;
        logic [11:0] pc = '0;
        bit gt = 0, eq = 0, lt = 0, done = 0;
        int ii = 0;
        exp_wa.delete(); exp_wd.delete(); exp_out.delete();
        exp_cyc = 0;
        for (int i = 0; i < 256; i++) sm[i] = bmem[i];
        for (int step = 0; step < 3000 && !done; step++) begin
            logic [15:0] w = sm[pc[7:0]];
            logic [3:0]  op = w[15:12];
            int          x = int'(w[7:0]);
            pc = pc + 12'd1;
            case (op)
                LD: begin r = sm[x]; exp_cyc += 5; end
                AD: begin r = r + sm[x]; exp_cyc += 5; end
                SB: begin r = r - sm[x]; exp_cyc += 5; end
                ST: begin sm[x] = r; exp_wa.push_back(w[11:0]); exp_wd.push_back(r); exp_cyc += 4; end
                CL: begin sm[x] = '0; exp_wa.push_back(w[11:0]); exp_wd.push_back('0); exp_cyc += 4; end
                IC, DC: begin
                    sm[x] = (op == IC) ? sm[x] + 16'd1 : sm[x] - 16'd1;
                    exp_wa.push_back(w[11:0]); exp_wd.push_back(sm[x]); exp_cyc += 6;
                end
                CP: begin
                    gt = $signed(sm[x]) > $signed(r);
                    eq = sm[x] == r;
                    lt = $signed(sm[x]) < $signed(r);
                    exp_cyc += 5;
                end
                JP, JG, JE, JL, JN: begin
                    if (op == JP || (op == JG && gt) || (op == JE && eq) ||
                        (op == JL && lt) || (op == JN && !eq)) pc = w[11:0];
                    exp_cyc += 4;
                end
                IN: begin
                    sm[x] = in_list[ii]; ii++;
                    exp_wa.push_back(w[11:0]); exp_wd.push_back(sm[x]); exp_cyc += 5;
                end
                OT: begin exp_out.push_back(sm[x]); exp_cyc += 6; end
                default: begin exp_cyc += 3; done = 1; end
            endcase
        end
    endtask

    // negedge monitor and port drivers
    always @(negedge clk) begin
        total_cyc++;
        if (!active) begin
            in_valid  <= 1'b0;
            out_ready <= 1'b0;
        end else begin
            bit iv, ordy;
            cyc++;
            if (mem_we) begin
                if (exp_wa.size() == 0) begin
                    chk(0, "R9", "write with none expected", {20'd0, mem_addr}, 0);
                end else begin
                    chk(mem_addr == exp_wa[0], "R2", "write address", mem_addr, exp_wa[0]);
                    chk(mem_wdata == exp_wd[0], "R3", "write data", mem_wdata, exp_wd[0]);
                    void'(exp_wa.pop_front()); void'(exp_wd.pop_front());
                end
            end
            iv   = (in_idx < in_list.size()) && (!stall_mode || (cyc % 3 == 2));
            ordy = !stall_mode || (cyc % 4 == 3);
            in_valid  = iv;
            in_data   = (in_idx < in_list.size()) ? in_list[in_idx] : 16'h0;
            out_ready = ordy;
            if (iv && in_ready) in_idx++;
            if (out_valid && ordy) begin
                if (exp_out.size() == 0) begin
                    chk(0, "R8", "output with none expected", out_data, 0);
                end else begin
                    chk(out_data == exp_out[0], "R8", "output word", out_data, exp_out[0]);
                    void'(exp_out.pop_front());
                end
            end
        end
        if (total_cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) bmem[i] = '0;
        in_list.delete();
    endtask

    task automatic run_prog(input string name, input bit stall, input bit timed);
        int n = 0;
        bit seen = 0;
        @(negedge clk);
        active = 0;
        rst_n = 0;
        stall_mode = stall;
        in_idx = 0;
        cyc = 0;
        run_iss();
        repeat (2) @(negedge clk);
        chk(!halted && !mem_we && !in_ready && !out_valid, "R1", "outputs quiet in reset",
            {halted, mem_we, in_ready, out_valid}, 0);
        rst_n = 1;
        active = 1;
        @(posedge clk); n++;
        @(negedge clk);
        chk(mem_addr == 12'd0, "R1", "first fetch address", mem_addr, 0);
        for (int k = 0; k < 5000 && !seen; k++) begin
            if (halted) seen = 1;
            else begin
                @(posedge clk); n++;
                @(negedge clk);
            end
        end
        chk(seen, "R9", {name, " reached halt"}, seen, 1);
        if (timed) chk(n == exp_cyc, "R10", {name, " cycles to halt"}, n, exp_cyc);
        repeat (12) begin
            @(negedge clk);
            chk(halted && !in_ready && !out_valid, "R9", "halt holds",
                {halted, in_ready, out_valid}, 3'b100);
        end
        chk(exp_wa.size() == 0, "R2", {name, " writes outstanding"}, exp_wa.size(), 0);
        chk(exp_out.size() == 0, "R8", {name, " outputs outstanding"}, exp_out.size(), 0);
        begin
            int bad = -1;
            for (int i = 0; i < 256; i++) if (bmem[i] !== sm[i] && bad < 0) bad = i;
            chk(bad < 0, "R6", {name, " final memory image"}, bad, -1);
        end
    endtask

    initial begin
        // arithmetic, wrap and in-memory operations
        clear_mem();
        bmem[0] = ins(LD, 200); bmem[1] = ins(AD, 201); bmem[2] = ins(ST, 210);
        bmem[3] = ins(SB, 202); bmem[4] = ins(ST, 211); bmem[5] = ins(IC, 203);
        bmem[6] = ins(DC, 204); bmem[7] = ins(CL, 205); bmem[8] = ins(ST, 212);
        bmem[9] = ins(HL, 0);
        bmem[200] = 16'h7FFF; bmem[201] = 16'h0001; bmem[202] = 16'h0002;
        bmem[203] = 16'hFFFF; bmem[204] = 16'h0000; bmem[205] = 16'h1234;
        run_prog("arith", 0, 1);
        chk(exp_cyc == 46, "R10", "arith reference cycle total", exp_cyc, 46);
        chk(bmem[210] == 16'h8000, "R2", "add wraps", bmem[210], 16'h8000);
        chk(bmem[211] == 16'h7FFE, "R2", "subtract", bmem[211], 16'h7FFE);
        chk(bmem[203] == 16'h0000, "R3", "increment wraps", bmem[203], 0);
        chk(bmem[204] == 16'hFFFF, "R3", "decrement wraps", bmem[204], 16'hFFFF);
        chk(bmem[205] == 16'h0000, "R3", "clear", bmem[205], 0);
        chk(bmem[212] == 16'h7FFE, "R3", "R untouched by cell ops", bmem[212], 16'h7FFE);

        // compare and branches
        clear_mem();
        bmem[0]  = ins(LD, 220); bmem[1]  = ins(CP, 221); bmem[2]  = ins(JG, 30);
        bmem[3]  = ins(JE, 30);  bmem[4]  = ins(JN, 6);   bmem[5]  = ins(HL, 0);
        bmem[6]  = ins(LD, 222); bmem[7]  = ins(JL, 9);   bmem[8]  = ins(HL, 0);
        bmem[9]  = ins(ST, 230); bmem[10] = ins(CP, 222); bmem[11] = ins(JN, 30);
        bmem[12] = ins(JE, 14);  bmem[13] = ins(HL, 0);   bmem[14] = ins(CP, 223);
        bmem[15] = ins(JL, 30);  bmem[16] = ins(JG, 18);  bmem[17] = ins(HL, 0);
        bmem[18] = ins(ST, 231); bmem[19] = ins(JP, 21);  bmem[20] = ins(HL, 0);
        bmem[21] = ins(ST, 232); bmem[22] = ins(HL, 0);
        bmem[30] = ins(ST, 233); bmem[31] = ins(HL, 0);
        bmem[220] = 16'h0001; bmem[221] = 16'hFFFF; bmem[222] = 16'h0005; bmem[223] = 16'h0009;
        run_prog("branch", 0, 1);
        chk(bmem[230] == 16'h0005, "R5", "flags kept across load, jumplt taken", bmem[230], 5);
        chk(bmem[231] == 16'h0005, "R4", "equal then greater paths", bmem[231], 5);
        chk(bmem[232] == 16'h0005, "R5", "unconditional jump", bmem[232], 5);
        chk(bmem[233] == 16'h0000, "R4", "signed less, no wrong branch", bmem[233], 0);

        // counted loop with jumpneq and decrement across the sign boundary
        clear_mem();
        bmem[0] = ins(LD, 252); bmem[1] = ins(IC, 251); bmem[2] = ins(CP, 251);
        bmem[3] = ins(JN, 1);   bmem[4] = ins(DC, 253); bmem[5] = ins(HL, 0);
        bmem[252] = 16'h0003; bmem[253] = 16'h8000;
        run_prog("loop", 0, 1);
        chk(bmem[251] == 16'h0003, "R5", "loop count", bmem[251], 3);
        chk(bmem[253] == 16'h7FFF, "R3", "decrement wraps to max", bmem[253], 16'h7FFF);

        // port traffic, first answered at once, then with stalls
        for (int pass = 0; pass < 2; pass++) begin
            clear_mem();
            bmem[0] = ins(IN, 240); bmem[1] = ins(IN, 241); bmem[2] = ins(OT, 241);
            bmem[3] = ins(OT, 240); bmem[4] = ins(LD, 240); bmem[5] = ins(AD, 241);
            bmem[6] = ins(ST, 242); bmem[7] = ins(OT, 242); bmem[8] = ins(HL, 0);
            in_list.push_back(16'h1111); in_list.push_back(16'hA0A0);
            run_prog(pass == 0 ? "io_fast" : "io_stall", pass == 1, pass == 0);
            chk(bmem[240] == 16'h1111, "R7", "first input stored", bmem[240], 16'h1111);
            chk(bmem[242] == 16'hB1B1, "R7", "inputs summed", bmem[242], 16'hB1B1);
            chk(in_idx == 2, "R7", "input words consumed", in_idx, 2);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule